// File: doc/BRIEF.md
# Character Cell Position Timer

This block turns the two flyback strobes of a monitor (horizontal and vertical, both active low) into the coordinates an on-screen text overlay needs on every dot clock: whether the current dot lies inside the character area, which memory row and column are being drawn, which of the 16 font lines applies, and which of the 10 dots inside the character cell is being shown. Flyback inputs are sampled on the dot clock, and their falling edges restart the dot count and the scan-line count.

The character area begins a programmable number of scan lines after the vertical strobe, in steps of four lines on top of one fixed line. It begins a programmable number of dots after the horizontal strobe, in steps of five dots on top of a fixed 47-dot delay. Every scan line carries a fixed stretch of N_COLS×10 display dots. Each character row is a programmable number of scan lines tall. The 16 font lines are stretched over that height. A row may be marked double-height, which doubles its span on screen so that the following memory row starts two heights later. A row may be marked double-width, which shows only the even memory columns, each dot twice. A vertical strobe that arrives while rows are still being drawn ends the frame at once.

Top module: `osd_cell_timer`

## Requirements
- R1: While reset is asserted and after it is released, before any flyback edge, disp_active is 0 and mem_row, char_col, font_line and dot_idx are 0.
- R2: With vertical code V (0 counts as 1), the first active scan line is the line opened by the (4×V+1)-th horizontal strobe after the vertical strobe's falling edge.
- R3: With horizontal code H (0 counts as 1) and hs = 47+5×H, if hflb_n is first sampled low at rising edge k, disp_active is 1 after edges k+1+hs through k+hs+N_COLS×10 of an active line, and 0 elsewhere in that line.
- R4: In a normal-width row, display dot p (0-based from the start of the active stretch) gives char_col = p/10 and dot_idx = p mod 10.
- R5: Each normal row lasts ch scan lines, where ch = row_height, or 16 when row_height < 16. Line j of the row gives font_line = floor(16×j/ch), and mem_row counts up from 0.
- R6: A row whose row_dbl_h bit (bit index = memory row) is 1 lasts 2×ch lines with font_line = floor(16×floor(j/2)/ch). The next memory row follows directly after it.
- R7: In a row whose row_dbl_w bit is 1, screen column c and dot d give char_col = c with bit 0 cleared and dot_idx = ((c mod 2)×10 + d)/2.
- R8: After the last memory row ends, no line is active until the next vertical strobe. A vertical strobe during drawing stops the frame, and the next frame starts again at memory row 0.
- R9: Whenever disp_active is 0, mem_row, char_col, font_line and dot_idx are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hflb_n | input | 1 | Horizontal flyback, active low |
| vflb_n | input | 1 | Vertical flyback, active low |
| vstart_code | input | VCODE_W (8) | Vertical start in steps of four lines |
| hstart_code | input | HCODE_W (7) | Horizontal start in steps of five dots |
| row_height | input | CH_W (6) | Scan lines per character row |
| row_dbl_h | input | N_ROWS (15) | Per memory row double-height enable |
| row_dbl_w | input | N_ROWS (15) | Per memory row double-width enable |
| disp_active | output | 1 | Current dot is inside the character area |
| mem_row | output | $clog2(N_ROWS) (4) | Memory row being drawn |
| char_col | output | $clog2(N_COLS) (5) | Memory column being drawn |
| font_line | output | $clog2(FONT_LINES) (4) | Font line of the character |
| dot_idx | output | $clog2(CHAR_DOTS) (4) | Dot within the font line |

## Verification
A flyback level first seen low at one rising edge becomes an internal strobe during the following cycle. The dot and line counters restart at the edge after that, so every horizontal result is due hs+1 edges after the sampling edge and every vertical result applies from the second edge of the line. The bench drives the strobes itself and counts edges from the one that first samples each low level. It samples the outputs at the falling clock edge and computes the expected row, column, font line and dot for that exact edge from the line number and the cycle offset. The first cycle of each line, where the strobe is still in flight, is expected to be idle.

// File: rtl/osd_timer_pkg.sv
package osd_timer_pkg;

   typedef enum logic [1:0] {
      VS_WAIT = 2'd0,
      VS_DRAW = 2'd1,
      VS_DONE = 2'd2
   } vscan_state_e;

   function automatic int unsigned floor_one(input int unsigned code);
      return (code == 0) ? 1 : code;
   endfunction

endpackage

// File: rtl/osd_flyback_edge.sv
module osd_flyback_edge #(
   parameter int STAGES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic lead_edge
);
   logic [STAGES-1:0] chain;
   logic              prev_lvl;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= strobe_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_lvl <= 1'b1;
      else        prev_lvl <= chain[STAGES-1];
   end

   assign lead_edge = prev_lvl & ~chain[STAGES-1];

endmodule

// File: rtl/osd_hscan.sv
module osd_hscan
   import osd_timer_pkg::*;
#(
   parameter int HCODE_W   = 7,
   parameter int HFIX      = 47,
   parameter int HSTEP     = 5,
   parameter int N_COLS    = 30,
   parameter int CHAR_DOTS = 10,
   localparam int COL_W    = $clog2(N_COLS),
   localparam int DOT_W    = $clog2(CHAR_DOTS),
   localparam int HC_W     = $clog2(HFIX + ((1 << HCODE_W) - 1) * HSTEP + N_COLS * CHAR_DOTS + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_start,
   input  logic [HCODE_W-1:0] hstart_code,
   output logic               h_on,
   output logic [COL_W-1:0]   h_col,
   output logic [DOT_W-1:0]   h_dot
);
   localparam logic [HC_W-1:0]  HC_MAX   = '1;
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(N_COLS - 1);
   localparam logic [DOT_W-1:0] LAST_DOT = DOT_W'(CHAR_DOTS - 1);

   logic [HC_W-1:0] dot_cnt;
   logic [HC_W-1:0] start_m1;

   assign start_m1 = HC_W'(HFIX) + HC_W'(floor_one(int'(hstart_code))) * HC_W'(HSTEP) - HC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dot_cnt <= '0;
      end else if (line_start) begin
         dot_cnt <= '0;
      end else if (dot_cnt != HC_MAX) begin
         dot_cnt <= dot_cnt + HC_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_on  <= 1'b0;
         h_col <= '0;
         h_dot <= '0;
      end else if (line_start) begin
         h_on  <= 1'b0;
         h_col <= '0;
         h_dot <= '0;
      end else if (dot_cnt == start_m1) begin
         h_on  <= 1'b1;
         h_col <= '0;
         h_dot <= '0;
      end else if (h_on) begin
         if (h_dot == LAST_DOT) begin
            h_dot <= '0;
            if (h_col == LAST_COL) begin
               h_on  <= 1'b0;
               h_col <= '0;
            end else begin
               h_col <= h_col + COL_W'(1);
            end
         end else begin
            h_dot <= h_dot + DOT_W'(1);
         end
      end
   end

endmodule

// File: rtl/osd_vscan.sv
module osd_vscan
   import osd_timer_pkg::*;
#(
   parameter int VCODE_W    = 8,
   parameter int VFIX       = 1,
   parameter int VSTEP      = 4,
   parameter int N_ROWS     = 15,
   parameter int CH_W       = 6,
   parameter int CH_MIN     = 16,
   parameter int FONT_LINES = 16,
   localparam int ROW_W     = $clog2(N_ROWS),
   localparam int FL_W      = $clog2(FONT_LINES),
   localparam int LIR_W     = CH_W + 1,
   localparam int ACC_W     = CH_W + 1,
   localparam int VL_W      = $clog2(VFIX + ((1 << VCODE_W) - 1) * VSTEP + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_start,
   input  logic               line_start,
   input  logic [VCODE_W-1:0] vstart_code,
   input  logic [CH_W-1:0]    row_height,
   input  logic [N_ROWS-1:0]  row_dbl_h,
   output logic               v_on,
   output logic [ROW_W-1:0]   v_row,
   output logic [FL_W-1:0]    v_font
);
   localparam logic [VL_W-1:0]  VL_MAX   = '1;
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(N_ROWS - 1);

   vscan_state_e     state;
   logic [VL_W-1:0]  line_cnt;
   logic [LIR_W-1:0] row_line;
   logic [CH_W-1:0]  acc;
   logic             half;
   logic [CH_W-1:0]  ch_eff;
   logic             dbl;
   logic [LIR_W-1:0] span_m1;
   logic [VL_W:0]    first_line;
   logic [ACC_W-1:0] acc_sum;
   logic             font_step;

   assign ch_eff     = (int'(row_height) < CH_MIN) ? CH_W'(CH_MIN) : row_height;
   assign dbl        = row_dbl_h[v_row];
   assign span_m1    = dbl ? ({ch_eff, 1'b0} - LIR_W'(1)) : ({1'b0, ch_eff} - LIR_W'(1));
   assign first_line = (VL_W+1)'(VFIX) + (VL_W+1)'(floor_one(int'(vstart_code))) * (VL_W+1)'(VSTEP);
   assign acc_sum    = {1'b0, acc} + ACC_W'(FONT_LINES);
   assign font_step  = (acc_sum >= {1'b0, ch_eff});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= VS_WAIT;
         line_cnt <= '0;
         row_line <= '0;
         v_row    <= '0;
         v_font   <= '0;
         acc      <= '0;
         half     <= 1'b0;
      end else if (frame_start) begin
         state    <= VS_WAIT;
         line_cnt <= '0;
      end else if (line_start) begin
         if (line_cnt != VL_MAX) line_cnt <= line_cnt + VL_W'(1);
         unique case (state)
            VS_WAIT: begin
               if (({1'b0, line_cnt} + (VL_W+1)'(1)) == first_line) begin
                  state    <= VS_DRAW;
                  v_row    <= '0;
                  row_line <= '0;
                  v_font   <= '0;
                  acc      <= '0;
                  half     <= 1'b0;
               end
            end
            VS_DRAW: begin
               if (row_line == span_m1) begin
                  row_line <= '0;
                  v_font   <= '0;
                  acc      <= '0;
                  half     <= 1'b0;
                  if (v_row == LAST_ROW) state <= VS_DONE;
                  else                   v_row <= v_row + ROW_W'(1);
               end else begin
                  row_line <= row_line + LIR_W'(1);
                  if (dbl && !half) begin
                     half <= 1'b1;
                  end else begin
                     half <= 1'b0;
                     if (font_step) begin
                        acc    <= CH_W'(acc_sum - {1'b0, ch_eff});
                        v_font <= v_font + FL_W'(1);
                     end else begin
                        acc <= CH_W'(acc_sum);
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign v_on = (state == VS_DRAW);

endmodule

// File: rtl/osd_cell_timer.sv
module osd_cell_timer
   import osd_timer_pkg::*;
#(
   parameter int N_ROWS      = 15,
   parameter int N_COLS      = 30,
   parameter int CHAR_DOTS   = 10,
   parameter int FONT_LINES  = 16,
   parameter int VCODE_W     = 8,
   parameter int HCODE_W     = 7,
   parameter int CH_W        = 6,
   parameter int CH_MIN      = 16,
   parameter int VFIX        = 1,
   parameter int VSTEP       = 4,
   parameter int HFIX        = 47,
   parameter int HSTEP       = 5,
   parameter int SYNC_STAGES = 1,
   localparam int ROW_W      = $clog2(N_ROWS),
   localparam int COL_W      = $clog2(N_COLS),
   localparam int DOT_W      = $clog2(CHAR_DOTS),
   localparam int FL_W       = $clog2(FONT_LINES),
   localparam int WDOT_W     = DOT_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hflb_n,
   input  logic               vflb_n,
   input  logic [VCODE_W-1:0] vstart_code,
   input  logic [HCODE_W-1:0] hstart_code,
   input  logic [CH_W-1:0]    row_height,
   input  logic [N_ROWS-1:0]  row_dbl_h,
   input  logic [N_ROWS-1:0]  row_dbl_w,
   output logic               disp_active,
   output logic [ROW_W-1:0]   mem_row,
   output logic [COL_W-1:0]   char_col,
   output logic [FL_W-1:0]    font_line,
   output logic [DOT_W-1:0]   dot_idx
);
   initial begin
      assert (CH_MIN >= FONT_LINES) else $error("CH_MIN must not be below FONT_LINES");
      assert (N_COLS % 2 == 0)      else $error("N_COLS must be even for double width");
      assert (SYNC_STAGES >= 1)     else $error("SYNC_STAGES must be at least 1");
      assert (CH_MIN < (1 << CH_W)) else $error("CH_MIN does not fit CH_W");
   end

   logic             h_lead, v_lead;
   logic             h_on, v_on;
   logic [COL_W-1:0] h_col;
   logic [DOT_W-1:0] h_dot;
   logic [ROW_W-1:0] v_row;
   logic [FL_W-1:0]  v_font;

   osd_flyback_edge #(.STAGES(SYNC_STAGES)) u_hedge (
      .clk(clk), .rst_n(rst_n), .strobe_n(hflb_n), .lead_edge(h_lead)
   );

   osd_flyback_edge #(.STAGES(SYNC_STAGES)) u_vedge (
      .clk(clk), .rst_n(rst_n), .strobe_n(vflb_n), .lead_edge(v_lead)
   );

   osd_hscan #(
      .HCODE_W(HCODE_W), .HFIX(HFIX), .HSTEP(HSTEP),
      .N_COLS(N_COLS), .CHAR_DOTS(CHAR_DOTS)
   ) u_hscan (
      .clk(clk), .rst_n(rst_n), .line_start(h_lead), .hstart_code(hstart_code),
      .h_on(h_on), .h_col(h_col), .h_dot(h_dot)
   );

   osd_vscan #(
      .VCODE_W(VCODE_W), .VFIX(VFIX), .VSTEP(VSTEP), .N_ROWS(N_ROWS),
      .CH_W(CH_W), .CH_MIN(CH_MIN), .FONT_LINES(FONT_LINES)
   ) u_vscan (
      .clk(clk), .rst_n(rst_n), .frame_start(v_lead), .line_start(h_lead),
      .vstart_code(vstart_code), .row_height(row_height), .row_dbl_h(row_dbl_h),
      .v_on(v_on), .v_row(v_row), .v_font(v_font)
   );

   logic              act;
   logic              wide;
   logic [WDOT_W-1:0] wide_dot;
   logic [COL_W-1:0]  col_sel;
   logic [DOT_W-1:0]  dot_sel;

   assign act      = v_on & h_on;
   assign wide     = row_dbl_w[v_row];
   assign wide_dot = (h_col[0] ? WDOT_W'(CHAR_DOTS) : '0) + {1'b0, h_dot};
   assign col_sel  = wide ? {h_col[COL_W-1:1], 1'b0} : h_col;
   assign dot_sel  = wide ? wide_dot[WDOT_W-1:1] : h_dot;

   assign disp_active = act;
   assign mem_row     = act ? v_row   : '0;
   assign char_col    = act ? col_sel : '0;
   assign font_line   = act ? v_font  : '0;
   assign dot_idx     = act ? dot_sel : '0;

endmodule

// File: rtl/osd_cell_timer_chk.sv
module osd_cell_timer_chk #(
   parameter int N_ROWS     = 15,
   parameter int N_COLS     = 30,
   parameter int CHAR_DOTS  = 10,
   parameter int FONT_LINES = 16,
   localparam int ROW_W     = $clog2(N_ROWS),
   localparam int COL_W     = $clog2(N_COLS),
   localparam int DOT_W     = $clog2(CHAR_DOTS),
   localparam int FL_W      = $clog2(FONT_LINES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_ROWS-1:0] row_dbl_w,
   input logic              disp_active,
   input logic [ROW_W-1:0]  mem_row,
   input logic [COL_W-1:0]  char_col,
   input logic [FL_W-1:0]   font_line,
   input logic [DOT_W-1:0]  dot_idx
);
   a_r4_dot_range: assert property (@(posedge clk) disable iff (!rst_n)
      disp_active |-> (int'(dot_idx) < CHAR_DOTS));

   a_r3_col_range: assert property (@(posedge clk) disable iff (!rst_n)
      disp_active |-> (int'(char_col) < N_COLS));

   a_r5_row_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_active && $past(disp_active)) |->
         (mem_row == $past(mem_row) && font_line == $past(font_line)));

   a_r4_dot_step: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_active && $past(disp_active) && !row_dbl_w[mem_row] &&
       int'($past(dot_idx)) != CHAR_DOTS - 1) |->
         (dot_idx == $past(dot_idx) + DOT_W'(1)));

   a_r7_even_col: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_active && row_dbl_w[mem_row]) |-> !char_col[0]);

endmodule

bind osd_cell_timer osd_cell_timer_chk #(
   .N_ROWS(N_ROWS), .N_COLS(N_COLS), .CHAR_DOTS(CHAR_DOTS), .FONT_LINES(FONT_LINES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .row_dbl_w(row_dbl_w), .disp_active(disp_active),
   .mem_row(mem_row), .char_col(char_col), .font_line(font_line), .dot_idx(dot_idx)
);

// File: tb/tb_osd_cell_timer.sv
module tb_osd_cell_timer;
   localparam int NR   = 4;
   localparam int NC   = 6;
   localparam int LINE = 140;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hflb_n = 1'b1;
   logic          vflb_n = 1'b1;
   logic [7:0]    vcode = 8'd1;
   logic [6:0]    hcode = 7'd1;
   logic [5:0]    ch = 6'd16;
   logic [NR-1:0] dblh = '0;
   logic [NR-1:0] dblw = '0;

   logic          disp_active;
   logic [1:0]    mem_row;
   logic [2:0]    char_col;
   logic [3:0]    font_line;
   logic [3:0]    dot_idx;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   osd_cell_timer #(.N_ROWS(NR), .N_COLS(NC)) dut (
      .clk(clk), .rst_n(rst_n), .hflb_n(hflb_n), .vflb_n(vflb_n),
      .vstart_code(vcode), .hstart_code(hcode), .row_height(ch),
      .row_dbl_h(dblh), .row_dbl_w(dblw),
      .disp_active(disp_active), .mem_row(mem_row), .char_col(char_col),
      .font_line(font_line), .dot_idx(dot_idx)
   );

   task automatic compare(input string ctx, input int l, input int c,
                          input int ea, input int er, input int ec,
                          input int ef, input int ed);
      string tag;
      n_vec++;
      if (int'(disp_active) != ea || int'(mem_row) != er || int'(char_col) != ec ||
          int'(font_line) != ef || int'(dot_idx) != ed) begin
         n_bad++;
         if (int'(disp_active) != ea) tag = "R2 R3 R8";
         else if (ea == 0)            tag = "R9";
         else if (int'(mem_row) != er || int'(font_line) != ef) tag = "R5 R6";
         else                         tag = "R4 R7";
         $display("FAIL %s [%s] line %0d cyc %0d: act/row/col/font/dot = %0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d",
                  tag, ctx, l, c, disp_active, mem_row, char_col, font_line, dot_idx,
                  ea, er, ec, ef, ed);
      end
   endtask

   // Expected outputs after edge c+1 of line l (edge 1 first samples hflb_n low).
   task automatic expect_at(input int l, input int c);
      int vs, hs, chc, e, r, lir, span, x, col, d, fl, ecol, edot;
      vs  = 1 + 4 * ((vcode == 0) ? 1 : int'(vcode));
      hs  = 47 + 5 * ((hcode == 0) ? 1 : int'(hcode));
      chc = (ch < 16) ? 16 : int'(ch);
      if (c == 0) begin compare("strobe", l, c, 0, 0, 0, 0, 0); return; end
      e = l - vs;
      if (e < 0) begin compare("above R2", l, c, 0, 0, 0, 0, 0); return; end
      r = -1; lir = 0;
      for (int i = 0; i < NR; i++) begin
         span = dblh[i] ? 2 * chc : chc;
         if (r < 0) begin
            if (e < span) begin r = i; lir = e; end
            else e = e - span;
         end
      end
      if (r < 0) begin compare("below R8", l, c, 0, 0, 0, 0, 0); return; end
      x = c - 1 - hs;
      if (x < 0 || x >= NC * 10) begin compare("side R3", l, c, 0, 0, 0, 0, 0); return; end
      col = x / 10;
      d   = x % 10;
      fl  = dblh[r] ? ((lir / 2) * 16) / chc : (lir * 16) / chc;
      if (dblw[r]) begin
         ecol = col - (col % 2);
         edot = ((col % 2) * 10 + d) / 2;
      end else begin
         ecol = col;
         edot = d;
      end
      compare("cell R4 R5 R6 R7", l, c, 1, r, ecol, fl, edot);
   endtask

   task automatic vsync_phase();
      for (int i = 0; i < 5; i++) begin
         vflb_n = (i < 3) ? 1'b0 : 1'b1;
         @(negedge clk);
         compare("vsync R8", 0, i, 0, 0, 0, 0, 0);
      end
   endtask

   task automatic frame(input int v, input int h, input int height,
                        input logic [NR-1:0] dh, input logic [NR-1:0] dw,
                        input int nlines);
      vcode = 8'(v);
      hcode = 7'(h);
      ch    = 6'(height);
      dblh  = dh;
      dblw  = dw;
      vsync_phase();
      for (int l = 1; l <= nlines; l++) begin
         for (int c = 0; c < LINE; c++) begin
            hflb_n = (c < 8) ? 1'b0 : 1'b1;
            @(negedge clk);
            expect_at(l, c);
         end
      end
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, got hang expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         compare("reset R1", 0, i, 0, 0, 0, 0, 0);
         @(negedge clk);
      end
      rst_n = 1'b1;
      @(negedge clk);
      compare("post reset R1", 0, 0, 0, 0, 0, 0, 0);

      // R2 R3 R4 R5 R8: plain frame, full height, trailing idle lines
      frame(1, 1, 16, 4'b0000, 4'b0000, 73);
      // R2 R3 zero codes, R6 double height on row 1, R7 double width on row 2
      frame(0, 0, 18, 4'b0010, 4'b0100, 98);
      // R5 height below 16 treated as 16, R6 R7 mixes, R8 cut mid row 1
      frame(2, 3, 10, 4'b1001, 4'b1011, 51);
      // R5 odd height, R7 on row 0, R8 cut in row 1
      frame(1, 2, 21, 4'b0000, 4'b0001, 40);
      // R8 restart at row 0 after a cut, R6 all rows double height
      frame(1, 1, 17, 4'b1111, 4'b0000, 146);

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule